// File: doc/BRIEF.md
# Descriptor Ring Address Tracker

This block holds the current descriptor address for two circular descriptor rings that live in host memory: one ring for transmit, one for receive. For each ring, software supplies a base byte address and a length code. The length code is the base-2 logarithm of the entry count. Both values are captured when the pointers are reloaded. Each descriptor slot is 8 bytes wide, so the current address is the captured base plus eight times the current entry index.

A one-cycle advance pulse per ring moves that ring to its next slot. The move after the last slot returns the ring to its base. An initialization pulse or a restart pulse sends both rings back to their bases, even when no new initialization has taken place. A level suspend input freezes both positions. When suspend is released, each ring continues from exactly the slot it held before.

The surrounding DMA engine uses the outputs only as addresses. The block does not fetch descriptors or test ownership.

Top module: `dring_ptr_unit`

## Requirements
- R1: After reset, both index outputs are 0, both address outputs are 0 and the configuration error output is 0.
- R2: An init pulse captures each ring's base and length code and sets both indices to 0. With ALIGN_CHECK=0 (the default), base bits [2:0] are cleared, so the address equals the base with its low three bits at zero.
- R3: A transmit advance pulse raises the transmit index by 1 and the transmit address by 8 one clock later. It leaves the receive ring untouched.
- R4: A receive advance pulse raises the receive index by 1 and the receive address by 8 one clock later. It leaves the transmit ring untouched. Both rings may advance in the same cycle.
- R5: An advance taken at index 2^code−1 returns that ring to index 0, with the address equal to the base.
- R6: Length code 0 gives a one-entry ring whose index stays at 0. Code 7 gives a 128-entry ring that reaches index 127 and then wraps.
- R7: A restart pulse reloads both rings to index 0 at their bases from any position, without an init.
- R8: An advance pulse in the same cycle as an init or restart pulse is ignored. The ring ends at index 0.
- R9: While suspend is high, advance pulses are ignored. After suspend falls, both rings are still at the slots held on entry, and advancing continues from there.
- R10: Changes to the base or length inputs have no effect on the addresses or on the wrap point until the next init or restart.
- R11: With ALIGN_CHECK=1, the base is used unmasked. The error output is 1 after a reload in which either base has a nonzero bit in [2:0], and it returns to 0 after a reload with both bases aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_base_i | input | ADDR_W | Transmit ring base byte address |
| tx_len_i | input | CODE_W | Transmit ring length code (log2 of entries) |
| rx_base_i | input | ADDR_W | Receive ring base byte address |
| rx_len_i | input | CODE_W | Receive ring length code (log2 of entries) |
| init_i | input | 1 | Initialization pulse: capture configuration, reload both rings |
| restart_i | input | 1 | Restart pulse: reload both rings to their bases |
| suspend_i | input | 1 | Level; freezes both ring positions |
| tx_adv_i | input | 1 | Advance the transmit ring by one slot |
| rx_adv_i | input | 1 | Advance the receive ring by one slot |
| tx_addr_o | output | ADDR_W | Current transmit descriptor address |
| rx_addr_o | output | ADDR_W | Current receive descriptor address |
| tx_idx_o | output | IDX_W | Current transmit entry index |
| rx_idx_o | output | IDX_W | Current receive entry index |
| cfg_err_o | output | 1 | Misaligned base seen at last reload (ALIGN_CHECK=1 only) |

## Verification
The two functions that collide are stepping a ring and reloading it. The bench drives an advance pulse in the same cycle as a restart pulse, and again in the same cycle as an init pulse. It does this after moving the rings away from slot 0, so that a stepped-then-reloaded result and a reloaded-then-stepped result would differ from the expected index 0 at the base. A second overlap puts an advance on the last slot of a ring, where stepping and wrapping meet. The bench also runs advances during suspend and then checks that the positions survive the release of suspend.

// File: rtl/dring_pkg.sv
package dring_pkg;
   localparam int unsigned DESC_SHIFT = 3;
   localparam int unsigned RING_CNT   = 2;

   typedef enum logic [0:0] {
      RING_TX = 1'b0,
      RING_RX = 1'b1
   } ring_sel_e;

   function automatic int unsigned code_width(input int unsigned max_log2);
      return (max_log2 < 1) ? 1 : $clog2(max_log2 + 1);
   endfunction
endpackage

// File: rtl/dring_base_cond.sv
module dring_base_cond #(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned SHIFT       = 3,
   parameter bit          ALIGN_CHECK = 1'b0
) (
   input  logic [ADDR_W-1:0] base_i,
   output logic [ADDR_W-1:0] base_o,
   output logic              misalign_o
);
   generate
      if (ALIGN_CHECK) begin : g_flag
         assign base_o     = base_i;
         assign misalign_o = |base_i[SHIFT-1:0];
      end else begin : g_force
         assign base_o     = {base_i[ADDR_W-1:SHIFT], {SHIFT{1'b0}}};
         assign misalign_o = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/dring_ring_ctr.sv
module dring_ring_ctr #(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned MAX_LOG2 = 7,
   parameter int unsigned SHIFT    = 3,
   localparam int unsigned IDX_W   = (MAX_LOG2 < 1) ? 1 : MAX_LOG2,
   localparam int unsigned CODE_W  = dring_pkg::code_width(MAX_LOG2)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              reload_i,
   input  logic              adv_i,
   input  logic              hold_i,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic              bad_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [IDX_W-1:0]  idx_o,
   output logic              bad_o
);
   logic [ADDR_W-1:0] base_q;
   logic [CODE_W-1:0] code_q;
   logic [IDX_W-1:0]  idx_q;
   logic [IDX_W-1:0]  last_idx;
   logic [CODE_W-1:0] code_clamp;
   logic              bad_q;

   always_comb begin
      code_clamp = (code_i > CODE_W'(MAX_LOG2)) ? CODE_W'(MAX_LOG2) : code_i;
      last_idx   = ~({IDX_W{1'b1}} << code_q);
      if (code_q == CODE_W'(0)) last_idx = '0;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         base_q <= '0;
         code_q <= '0;
         idx_q  <= '0;
         bad_q  <= 1'b0;
      end else if (reload_i) begin
         base_q <= base_i;
         code_q <= code_clamp;
         idx_q  <= '0;
         bad_q  <= bad_i;
      end else if (adv_i && !hold_i) begin
         idx_q <= (idx_q == last_idx) ? '0 : idx_q + IDX_W'(1);
      end
   end

   assign addr_o = base_q + {{(ADDR_W-IDX_W-SHIFT){1'b0}}, idx_q, {SHIFT{1'b0}}};
   assign idx_o  = idx_q;
   assign bad_o  = bad_q;
endmodule

// File: rtl/dring_ptr_unit.sv
module dring_ptr_unit #(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned MAX_LOG2    = 7,
   parameter bit          ALIGN_CHECK = 1'b0,
   localparam int unsigned IDX_W      = (MAX_LOG2 < 1) ? 1 : MAX_LOG2,
   localparam int unsigned CODE_W     = dring_pkg::code_width(MAX_LOG2)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ADDR_W-1:0] tx_base_i,
   input  logic [CODE_W-1:0] tx_len_i,
   input  logic [ADDR_W-1:0] rx_base_i,
   input  logic [CODE_W-1:0] rx_len_i,
   input  logic              init_i,
   input  logic              restart_i,
   input  logic              suspend_i,
   input  logic              tx_adv_i,
   input  logic              rx_adv_i,
   output logic [ADDR_W-1:0] tx_addr_o,
   output logic [ADDR_W-1:0] rx_addr_o,
   output logic [IDX_W-1:0]  tx_idx_o,
   output logic [IDX_W-1:0]  rx_idx_o,
   output logic              cfg_err_o
);
   import dring_pkg::*;

   localparam int unsigned NR = RING_CNT;

   generate
      if (ADDR_W < IDX_W + DESC_SHIFT + 1) begin : g_chk_width
         $error("ADDR_W too small for ring index and descriptor stride");
      end
      if (MAX_LOG2 > 16) begin : g_chk_depth
         $error("MAX_LOG2 above supported ring depth");
      end
   endgenerate

   logic              reload;
   logic [ADDR_W-1:0] base_raw [NR];
   logic [ADDR_W-1:0] base_ok  [NR];
   logic [CODE_W-1:0] code_in  [NR];
   logic              adv_in   [NR];
   logic              mis      [NR];
   logic [ADDR_W-1:0] addr_out [NR];
   logic [IDX_W-1:0]  idx_out  [NR];
   logic              bad_out  [NR];

   assign reload = init_i | restart_i;

   assign base_raw[RING_TX] = tx_base_i;
   assign base_raw[RING_RX] = rx_base_i;
   assign code_in[RING_TX]  = tx_len_i;
   assign code_in[RING_RX]  = rx_len_i;
   assign adv_in[RING_TX]   = tx_adv_i;
   assign adv_in[RING_RX]   = rx_adv_i;

   generate
      for (genvar g = 0; g < NR; g++) begin : g_ring
         dring_base_cond #(
            .ADDR_W      (ADDR_W),
            .SHIFT       (DESC_SHIFT),
            .ALIGN_CHECK (ALIGN_CHECK)
         ) u_cond (
            .base_i     (base_raw[g]),
            .base_o     (base_ok[g]),
            .misalign_o (mis[g])
         );

         dring_ring_ctr #(
            .ADDR_W   (ADDR_W),
            .MAX_LOG2 (MAX_LOG2),
            .SHIFT    (DESC_SHIFT)
         ) u_ctr (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .reload_i (reload),
            .adv_i    (adv_in[g]),
            .hold_i   (suspend_i),
            .base_i   (base_ok[g]),
            .code_i   (code_in[g]),
            .bad_i    (mis[g]),
            .addr_o   (addr_out[g]),
            .idx_o    (idx_out[g]),
            .bad_o    (bad_out[g])
         );
      end
   endgenerate

   assign tx_addr_o = addr_out[RING_TX];
   assign rx_addr_o = addr_out[RING_RX];
   assign tx_idx_o  = idx_out[RING_TX];
   assign rx_idx_o  = idx_out[RING_RX];
   assign cfg_err_o = bad_out[RING_TX] | bad_out[RING_RX];
endmodule

// File: rtl/dring_ptr_chk.sv
module dring_ptr_chk #(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned IDX_W       = 7,
   parameter bit          ALIGN_CHECK = 1'b0
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              init_i,
   input logic              restart_i,
   input logic              suspend_i,
   input logic              tx_adv_i,
   input logic              rx_adv_i,
   input logic [ADDR_W-1:0] tx_addr_o,
   input logic [ADDR_W-1:0] rx_addr_o,
   input logic [IDX_W-1:0]  tx_idx_o,
   input logic [IDX_W-1:0]  rx_idx_o
);
   logic rl;
   assign rl = init_i | restart_i;

   AST_RELOAD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rl |=> (tx_idx_o == '0 && rx_idx_o == '0)); // R7

   AST_SUSPEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (suspend_i && !rl) |=> ($stable(tx_idx_o) && $stable(rx_idx_o)
                              && $stable(tx_addr_o) && $stable(rx_addr_o))); // R9

   AST_TX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tx_adv_i && !suspend_i && !rl) |=>
         (tx_idx_o == IDX_W'($past(tx_idx_o) + 1'b1) || tx_idx_o == '0)); // R3

   AST_RX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rx_adv_i && !suspend_i && !rl) |=>
         (rx_idx_o == IDX_W'($past(rx_idx_o) + 1'b1) || rx_idx_o == '0)); // R4

   AST_TX_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!tx_adv_i && !rl) |=> ($stable(tx_idx_o) && $stable(tx_addr_o))); // R10

   AST_RX_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!rx_adv_i && !rl) |=> ($stable(rx_idx_o) && $stable(rx_addr_o))); // R10

   generate
      if (!ALIGN_CHECK) begin : g_align
         AST_ADDR_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (tx_addr_o[2:0] == 3'b000 && rx_addr_o[2:0] == 3'b000)); // R2
      end
   endgenerate
endmodule

bind dring_ptr_unit dring_ptr_chk #(
   .ADDR_W      (ADDR_W),
   .IDX_W       (IDX_W),
   .ALIGN_CHECK (ALIGN_CHECK)
) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .init_i    (init_i),
   .restart_i (restart_i),
   .suspend_i (suspend_i),
   .tx_adv_i  (tx_adv_i),
   .rx_adv_i  (rx_adv_i),
   .tx_addr_o (tx_addr_o),
   .rx_addr_o (rx_addr_o),
   .tx_idx_o  (tx_idx_o),
   .rx_idx_o  (rx_idx_o)
);

// File: tb/tb_dring_ptr_unit.sv
module tb_dring_ptr_unit;
   localparam int ADDR_W = 32;
   localparam int IDX_W  = 7;
   localparam int CODE_W = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] tx_base = '0, rx_base = '0;
   logic [CODE_W-1:0] tx_len = '0, rx_len = '0;
   logic              init = 0, restart = 0, susp = 0, tx_adv = 0, rx_adv = 0;
   logic [ADDR_W-1:0] tx_addr, rx_addr, f_tx_addr, f_rx_addr;
   logic [IDX_W-1:0]  tx_idx, rx_idx, f_tx_idx, f_rx_idx;
   logic              err, f_err;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #4 clk = ~clk;

   dring_ptr_unit dut (
      .clk_i(clk), .rst_ni(rst_n),
      .tx_base_i(tx_base), .tx_len_i(tx_len), .rx_base_i(rx_base), .rx_len_i(rx_len),
      .init_i(init), .restart_i(restart), .suspend_i(susp),
      .tx_adv_i(tx_adv), .rx_adv_i(rx_adv),
      .tx_addr_o(tx_addr), .rx_addr_o(rx_addr),
      .tx_idx_o(tx_idx), .rx_idx_o(rx_idx), .cfg_err_o(err)
   );

   dring_ptr_unit #(.ALIGN_CHECK(1'b1)) dut_flag (
      .clk_i(clk), .rst_ni(rst_n),
      .tx_base_i(tx_base), .tx_len_i(tx_len), .rx_base_i(rx_base), .rx_len_i(rx_len),
      .init_i(init), .restart_i(restart), .suspend_i(susp),
      .tx_adv_i(tx_adv), .rx_adv_i(rx_adv),
      .tx_addr_o(f_tx_addr), .rx_addr_o(f_rx_addr),
      .tx_idx_o(f_tx_idx), .rx_idx_o(f_rx_idx), .cfg_err_o(f_err)
   );

   typedef struct packed {
      logic [1:0]       op;
      logic [IDX_W-1:0] etx;
      logic [IDX_W-1:0] erx;
   } vec_t;

   // op: bit0 = transmit advance, bit1 = receive advance
   // tx ring 4 entries at 0x1000, rx ring 8 entries at 0x2008
   localparam vec_t TBL [12] = '{
      '{2'd1, 7'd1, 7'd0}, '{2'd2, 7'd1, 7'd1}, '{2'd3, 7'd2, 7'd2},
      '{2'd1, 7'd3, 7'd2}, '{2'd3, 7'd0, 7'd3}, '{2'd0, 7'd0, 7'd3},
      '{2'd2, 7'd0, 7'd4}, '{2'd2, 7'd0, 7'd5}, '{2'd2, 7'd0, 7'd6},
      '{2'd3, 7'd1, 7'd7}, '{2'd2, 7'd1, 7'd0}, '{2'd1, 7'd2, 7'd0}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic pulse(input logic t, input logic r, input logic i, input logic s);
      tx_adv = t; rx_adv = r; init = i; restart = s;
      @(negedge clk);
      tx_adv = 0; rx_adv = 0; init = 0; restart = 0;
   endtask

   task automatic chk_pos(input string tag, input int et, input int er,
                          input logic [31:0] tb, input logic [31:0] rb);
      chk({tag, " tx_idx"}, 32'(tx_idx), 32'(et));
      chk({tag, " rx_idx"}, 32'(rx_idx), 32'(er));
      chk({tag, " tx_addr"}, tx_addr, tb + 32'(et * 8));
      chk({tag, " rx_addr"}, rx_addr, rb + 32'(er * 8));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk_pos("R1 reset", 0, 0, 32'h0, 32'h0);
      chk("R1 reset err", 32'(err), 0);
      chk("R1 reset err flag", 32'(f_err), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 init
      tx_base = 32'h1000; tx_len = 3'd2; rx_base = 32'h2008; rx_len = 3'd3;
      pulse(0, 0, 1, 0);
      chk_pos("R2 init", 0, 0, 32'h1000, 32'h2008);

      // R3 R4 R5 table walk
      foreach (TBL[k]) begin
         pulse(TBL[k].op[0], TBL[k].op[1], 0, 0);
         chk_pos($sformatf("R3/R4/R5 vec%0d", k), int'(TBL[k].etx), int'(TBL[k].erx),
                 32'h1000, 32'h2008);
      end
      pulse(0, 1, 0, 0);
      chk_pos("R4 extra", 2, 1, 32'h1000, 32'h2008);

      // R10 config changes without reload
      tx_base = 32'h3000; tx_len = 3'd0;
      @(negedge clk);
      chk_pos("R10 held", 2, 1, 32'h1000, 32'h2008);
      pulse(1, 0, 0, 0);
      pulse(1, 0, 0, 0);
      chk_pos("R10 old wrap", 0, 1, 32'h1000, 32'h2008);
      pulse(1, 0, 0, 0);

      // R7 restart with R8 colliding advances
      pulse(1, 1, 0, 1);
      chk_pos("R7 R8 restart", 0, 0, 32'h3000, 32'h2008);

      // R6 single entry ring
      pulse(1, 0, 0, 0);
      chk_pos("R6 code0", 0, 0, 32'h3000, 32'h2008);

      // R8 init colliding with advances from nonzero position
      pulse(0, 1, 0, 0);
      pulse(1, 1, 1, 0);
      chk_pos("R8 init", 0, 0, 32'h3000, 32'h2008);

      // R9 suspend
      pulse(0, 1, 0, 0);
      pulse(0, 1, 0, 0);
      susp = 1'b1;
      pulse(1, 1, 0, 0);
      pulse(1, 1, 0, 0);
      chk_pos("R9 frozen", 0, 2, 32'h3000, 32'h2008);
      susp = 1'b0;
      @(negedge clk);
      chk_pos("R9 released", 0, 2, 32'h3000, 32'h2008);
      pulse(0, 1, 0, 0);
      chk_pos("R9 resume", 0, 3, 32'h3000, 32'h2008);

      // R6 largest ring
      tx_base = 32'h5000; tx_len = 3'd7;
      pulse(0, 0, 1, 0);
      for (int n = 0; n < 127; n++) pulse(1, 0, 0, 0);
      chk("R6 code7 idx", 32'(tx_idx), 127);
      chk("R6 code7 addr", tx_addr, 32'h53F8);
      pulse(1, 0, 0, 0);
      chk("R6 code7 wrap idx", 32'(tx_idx), 0);
      chk("R6 code7 wrap addr", tx_addr, 32'h5000);

      // R2 forced alignment, R11 flagged variant
      tx_base = 32'h4005; rx_base = 32'h6000;
      pulse(0, 0, 1, 0);
      chk("R2 masked addr", tx_addr, 32'h4000);
      chk("R2 no err", 32'(err), 0);
      chk("R11 raw addr", f_tx_addr, 32'h4005);
      chk("R11 err set", 32'(f_err), 1);
      tx_base = 32'h4000;
      pulse(0, 0, 1, 0);
      chk("R11 err clear", 32'(f_err), 0);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule